// File: doc/BRIEF.md
# Two-Plane Sum-of-Products Logic Core

This block evaluates a set of Boolean functions in sum-of-products form. The structure is fully configurable. Each of the N_IN inputs is buffered into a true line and a complemented line. A programmable AND plane builds N_TERM product terms from any chosen subset of those lines. A programmable OR plane lets each of the N_OUT outputs sum any subset of the terms. A per-output inversion bit can then complement each sum.

Because the OR plane is programmable, a single product term can feed several outputs. A set of functions fits as long as the distinct product terms they need number no more than N_TERM.

The connection pattern is held in a serial configuration chain that loads one bit per clock while `cfg_en` is high. Apart from that chain, the datapath from `x_in` to `y_out` is purely combinational. Choosing and minimising the terms is left to whatever produces the configuration stream.

Top module: `sop_array_core`

## Requirements
- R1: Literal line 2i carries input `x_in[i]`, and literal line 2i+1 carries its complement.
- R2: A product term is the AND of the literal lines connected to it. A term with no connected literals evaluates to 1. A term connected to both polarities of one input evaluates to 0.
- R3: Before inversion, each output is the OR of the product terms connected to it. One term may feed several outputs, and an output with no connected terms evaluates to 0.
- R4: When an output's inversion bit is 1, that output delivers the complement of its sum.
- R5: Configuration bit positions, counted in load order from 0, are as follows:
  - Bit `t*2*N_IN + j` connects literal j to term t.
  - Bit `N_TERM*2*N_IN + o*N_TERM + t` connects term t to output o.
  - The final N_OUT bits are the inversion bits, with output 0 first.
- R6: While `cfg_en` is high, every bit of `y_out` is 0.
- R7: Reset clears every configuration bit, so after reset all outputs read 0. While `cfg_en` is low, `cfg_bit` has no effect on the stored configuration.
- R8: With 3 inputs (A=`x_in[2]`, B=`x_in[1]`, C=`x_in[0]`) and 4 terms, programme the terms A·B', A'·B·C and A·B, set output 0 to terms 0 and 1, and set output 1 to terms 0 and 2. The result is `y_out[0]` = A·B' + A'·B·C and `y_out[1]` = A·B' + A·B.
- R9: For any configuration and any input pattern, each output equals the inversion bit XOR the OR over connected terms of the AND over their connected literals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst | input | 1 | Synchronous active-high reset; clears the configuration |
| cfg_en | input | 1 | Shift one configuration bit per clock; outputs held at 0 |
| cfg_bit | input | 1 | Serial configuration data, first bit is position 0 |
| x_in | input | N_IN | Function inputs |
| y_out | output | N_OUT | Function outputs |

## Verification
The bound checker watches the configuration chain and the outputs on every cycle. It confirms four things: the outputs stay at 0 during loading, the stored pattern is frozen while loading is off, each new serial bit enters at the chain head, and reset clears the pattern. It also checks that any term with no literals reads 1 and that any output with no terms reads its inversion bit. Only the bench scenarios can show that the bit positions map to the intended literals, terms and outputs, that a shared term drives two outputs at once, and that the full sum-of-products value matches across random configurations and all input patterns.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_COMP = 1'b1
    } lit_pol_e;

    function automatic int and_bits(input int n_in, input int n_term);
        return n_term * 2 * n_in;
    endfunction

    function automatic int or_bits(input int n_term, input int n_out);
        return n_out * n_term;
    endfunction

    function automatic int chain_len(input int n_in, input int n_term, input int n_out);
        return and_bits(n_in, n_term) + or_bits(n_term, n_out) + n_out;
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
    parameter int LEN = 34
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           shift_in,
    output logic [LEN-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (shift_en) begin
            cfg_q <= {shift_in, cfg_q[LEN-1:1]};
        end
    end
endmodule

// File: rtl/sop_literal_buf.sv
module sop_literal_buf
    import sop_array_pkg::*;
#(
    parameter int N_IN = 3
) (
    input  logic [N_IN-1:0]   x,
    output logic [2*N_IN-1:0] lits
);
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lits[2*i]   = x[i] ^ logic'(POL_TRUE);
        assign lits[2*i+1] = x[i] ^ logic'(POL_COMP);
    end
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
    parameter int N_LIT  = 6,
    parameter int N_TERM = 4
) (
    input  logic [N_LIT-1:0]        lits,
    input  logic [N_TERM*N_LIT-1:0] conn,
    output logic [N_TERM-1:0]       terms
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_LIT-1:0] sel;
        assign sel      = conn[t*N_LIT +: N_LIT];
        assign terms[t] = &(lits | ~sel);
    end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2
) (
    input  logic [N_TERM-1:0]       terms,
    input  logic [N_OUT*N_TERM-1:0] conn,
    input  logic [N_OUT-1:0]        inv,
    input  logic                    hold,
    output logic [N_OUT-1:0]        y
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic sum;
        assign sum  = |(terms & conn[o*N_TERM +: N_TERM]);
        assign y[o] = hold ? 1'b0 : (sum ^ inv[o]);
    end
endmodule

// File: rtl/sop_array_core.sv
module sop_array_core
    import sop_array_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  x_in,
    output logic [N_OUT-1:0] y_out
);
    localparam int N_LIT  = 2 * N_IN;
    localparam int A_BITS = and_bits(N_IN, N_TERM);
    localparam int O_BITS = or_bits(N_TERM, N_OUT);
    localparam int LEN    = chain_len(N_IN, N_TERM, N_OUT);

    logic [LEN-1:0]    cfg_q;
    logic [N_LIT-1:0]  lits;
    logic [N_TERM-1:0] term_q;

    sop_cfg_chain #(.LEN(LEN)) i_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .shift_in (cfg_bit),
        .cfg_q    (cfg_q)
    );

    sop_literal_buf #(.N_IN(N_IN)) i_lits (
        .x    (x_in),
        .lits (lits)
    );

    sop_and_plane #(.N_LIT(N_LIT), .N_TERM(N_TERM)) i_and (
        .lits  (lits),
        .conn  (cfg_q[A_BITS-1:0]),
        .terms (term_q)
    );

    sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) i_or (
        .terms (term_q),
        .conn  (cfg_q[A_BITS +: O_BITS]),
        .inv   (cfg_q[A_BITS+O_BITS +: N_OUT]),
        .hold  (cfg_en),
        .y     (y_out)
    );
endmodule

// File: rtl/sop_array_core_chk.sv
module sop_array_core_chk
    import sop_array_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int N_TERM = 4,
    parameter int N_OUT  = 2
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic                                   cfg_en,
    input logic                                   cfg_bit,
    input logic [chain_len(N_IN,N_TERM,N_OUT)-1:0] cfg_q,
    input logic [N_TERM-1:0]                      term_q,
    input logic [N_OUT-1:0]                       y_out
);
    localparam int N_LIT  = 2 * N_IN;
    localparam int A_BITS = and_bits(N_IN, N_TERM);
    localparam int O_BITS = or_bits(N_TERM, N_OUT);
    localparam int LEN    = chain_len(N_IN, N_TERM, N_OUT);

    AST_QUIET_WHILE_LOADING: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> y_out == '0); // R6

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q)); // R7

    AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_q[LEN-1] == $past(cfg_bit)); // R5

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_q == '0); // R7

    for (genvar t = 0; t < N_TERM; t++) begin : g_tchk
        AST_EMPTY_TERM_HIGH: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[t*N_LIT +: N_LIT] == '0) |-> term_q[t]); // R2
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_ochk
        AST_EMPTY_SUM_LOW: assert property (@(posedge clk) disable iff (rst)
            (!cfg_en && cfg_q[A_BITS+o*N_TERM +: N_TERM] == '0)
                |-> y_out[o] == cfg_q[A_BITS+O_BITS+o]); // R3
    end
endmodule

bind sop_array_core sop_array_core_chk #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT)
) i_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_en  (cfg_en),
    .cfg_bit (cfg_bit),
    .cfg_q   (cfg_q),
    .term_q  (term_q),
    .y_out   (y_out)
);

// File: tb/test_sop_array_core.sv
module test_sop_array_core;
    localparam int N_IN   = 3;
    localparam int N_TERM = 4;
    localparam int N_OUT  = 2;
    localparam int N_LIT  = 2 * N_IN;
    localparam int A_BITS = N_TERM * N_LIT;
    localparam int O_BITS = N_OUT * N_TERM;
    localparam int LEN    = A_BITS + O_BITS + N_OUT;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_en = 1'b0;
    logic             cfg_bit = 1'b0;
    logic [N_IN-1:0]  x_in = '0;
    logic [N_OUT-1:0] y_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    sop_array_core #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) i_sop_array_core (
        .clk (clk), .rst (rst), .cfg_en (cfg_en), .cfg_bit (cfg_bit),
        .x_in (x_in), .y_out (y_out)
    );

    always #5 clk = ~clk;

    function automatic logic [N_OUT-1:0] model(input logic [LEN-1:0] c, input logic [N_IN-1:0] x);
        logic [N_OUT-1:0] r;
        logic [N_TERM-1:0] tv;
        for (int t = 0; t < N_TERM; t++) begin
            tv[t] = 1'b1;
            for (int j = 0; j < N_LIT; j++) begin
                logic lit;
                lit = x[j/2] ^ logic'(j % 2);
                if (c[t*N_LIT+j] && !lit) tv[t] = 1'b0;
            end
        end
        for (int o = 0; o < N_OUT; o++) begin
            logic s;
            s = 1'b0;
            for (int t = 0; t < N_TERM; t++)
                if (c[A_BITS+o*N_TERM+t] && tv[t]) s = 1'b1;
            r[o] = s ^ c[A_BITS+O_BITS+o];
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: y_out=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic load(input logic [LEN-1:0] v);
        for (int i = 0; i < LEN; i++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_bit = v[i];
            if (i == LEN / 2) begin
                #1 check("R6 outputs quiet while loading", y_out, '0);
            end
        end
        @(negedge clk);
        cfg_en  = 1'b0;
        cfg_bit = 1'b0;
    endtask

    task automatic sweep(input string req, input logic [LEN-1:0] v);
        for (int x = 0; x < (1 << N_IN); x++) begin
            @(negedge clk);
            x_in = x[N_IN-1:0];
            #1 check(req, y_out, model(v, x_in));
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [LEN-1:0] v;
        int seed;
        seed = $urandom(32'h5EED_0011);

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state, every pattern reads 0
        for (int x = 0; x < (1 << N_IN); x++) begin
            @(negedge clk);
            x_in = x[N_IN-1:0];
            #1 check("R7 reset clears configuration", y_out, '0);
        end

        // R4 R5: only output 1 inversion bit set -> 2'b10 everywhere
        v = '0;
        v[A_BITS+O_BITS+1] = 1'b1;
        load(v);
        for (int x = 0; x < (1 << N_IN); x++) begin
            @(negedge clk);
            x_in = x[N_IN-1:0];
            #1 check("R4 R5 inversion bit position", y_out, 2'b10);
        end

        // R1 R2: term0 = A and A' (always 0) to out0; term1 empty (1) to out1
        v = '0;
        v[0*N_LIT+4] = 1'b1;
        v[0*N_LIT+5] = 1'b1;
        v[A_BITS+0*N_TERM+0] = 1'b1;
        v[A_BITS+1*N_TERM+1] = 1'b1;
        load(v);
        for (int x = 0; x < (1 << N_IN); x++) begin
            @(negedge clk);
            x_in = x[N_IN-1:0];
            #1 check("R2 contradictory and empty terms", y_out, 2'b10);
        end

        // R1 R3: term0 = A true to out0, term1 = A' to out1
        v = '0;
        v[0*N_LIT+4] = 1'b1;
        v[1*N_LIT+5] = 1'b1;
        v[A_BITS+0*N_TERM+0] = 1'b1;
        v[A_BITS+1*N_TERM+1] = 1'b1;
        load(v);
        for (int x = 0; x < (1 << N_IN); x++) begin
            @(negedge clk);
            x_in = x[N_IN-1:0];
            #1 check("R1 literal polarity", y_out, {~x_in[2], x_in[2]});
        end

        // R8: shared-term example (A=x[2], B=x[1], C=x[0])
        v = '0;
        v[0*N_LIT+4] = 1'b1; v[0*N_LIT+3] = 1'b1;
        v[1*N_LIT+5] = 1'b1; v[1*N_LIT+2] = 1'b1; v[1*N_LIT+0] = 1'b1;
        v[2*N_LIT+4] = 1'b1; v[2*N_LIT+2] = 1'b1;
        v[A_BITS+0*N_TERM+0] = 1'b1; v[A_BITS+0*N_TERM+1] = 1'b1;
        v[A_BITS+1*N_TERM+0] = 1'b1; v[A_BITS+1*N_TERM+2] = 1'b1;
        load(v);
        for (int x = 0; x < (1 << N_IN); x++) begin
            logic a, b, c;
            @(negedge clk);
            x_in = x[N_IN-1:0];
            a = x_in[2]; b = x_in[1]; c = x_in[0];
            #1 check("R8 shared term example", y_out,
                     {(a & ~b) | (a & b), (a & ~b) | (~a & b & c)});
        end

        // R7: cfg_bit toggling with cfg_en low leaves function unchanged
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cfg_bit = ~cfg_bit;
        end
        cfg_bit = 1'b0;
        sweep("R7 cfg_bit ignored while idle", v);

        // R9: random configurations
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < LEN; i++) begin
                if (i < A_BITS) v[i] = ($urandom % 4) == 0;
                else            v[i] = $urandom % 2;
            end
            load(v);
            sweep("R9 random configuration", v);
        end

        // R7: reset after a load clears again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int x = 0; x < (1 << N_IN); x++) begin
            @(negedge clk);
            x_in = x[N_IN-1:0];
            #1 check("R7 reset after load", y_out, '0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule